// File: doc/BRIEF.md
# Vectored Interrupt Controller with Bitwise Mask

This block arbitrates ten interrupt requests for a microprogram sequencer. Eight requests come from external pins. The other two are internal: a counter-underflow request, raised when the counter sign input rises, and a stack-overflow request. Each request has a pending latch and a mask bit. The controller also holds a global enable bit, a latched/transparent input mode and an in-progress flag. When an unmasked request is pending, interrupts are enabled and no interrupt is in progress, the block emits a one-cycle take strobe. In the same cycle it drives the 16-bit vector of the winning request, read from an internal vector file.

The sequencer controls the block through a 4-bit opcode and a 16-bit data word. The opcodes update the mask bit by bit, switch the enable and the mode, clear the interrupt being serviced or all external latches, and clear each internal request. Others load, write and read the vector file through an auto-incrementing pointer, or read back the status word. Stacking the return address and selecting the program counter are left to the sequencer.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, take and in_prog are 0, rd_data is 0, every mask bit is 0 (unmasked), the global enable is 0 (disabled) and the mode is latched.
- R2: Request k is the counter underflow for k=0, the stack overflow for k=1 and ext_req[k-2] for k=2..9. The mask bit for request k is status bit 6+k, and 1 means masked. The status word holds the mask in bits 15:6, the enable in bit 2 and the mode in bit 0 (1 = transparent), with all other bits 0. Opcode 13 loads the status word into rd_data at the next edge.
- R3: Opcode 6 sets each mask bit whose data_in bit (6+k) is 1. Opcode 5 clears each such bit. Mask bits whose data bit is 0 keep their value, and data_in[5:0] has no effect on the mask.
- R4: Opcode 8 sets the global enable and opcode 7 clears it. While the enable is clear no interrupt is taken, but external requests keep being latched and are taken once the enable is set.
- R5: When at an edge the enable is set, in_prog is 0 and an unmasked request is pending, take is 1 for the following cycle, vec_addr shows the winner's vector entry and in_prog becomes 1. vec_addr holds that value until the next take. In latched mode, a request sampled high at edge N is taken at edge N+1.
- R6: When several unmasked requests are pending, the highest-numbered one is taken.
- R7: While in_prog is 1, no further interrupt is taken.
- R8: Opcode 1 clears in_prog and the latch of the interrupt last taken, if that interrupt is external. A pending interrupt can be taken no earlier than the edge after the opcode's edge.
- R9: Opcode 2 clears in_prog and all eight external latches.
- R10: Opcodes 1 and 2 never clear the internal requests. The underflow request latches when cnt_sign rises and is cleared by opcode 12. The overflow request latches while ovf_req is high and is cleared by opcode 11. A request that is present in the same cycle as its clear opcode remains set.
- R11: Opcode 10 selects transparent mode and empties the external latches. In that mode an external request counts only in the cycle in which it is high, and it is taken at the edge that samples it. Opcode 9 returns to latched mode.
- R12: Opcode 4 writes data_in into the vector entry selected by the 4-bit pointer. Opcode 3 loads that entry into rd_data. Both then increment the pointer, which wraps from 15 to 0. Opcode 11 loads the pointer from data_in[7:4]. Pointer values 10 to 15 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_req | input | 8 | External interrupt request lines |
| ovf_req | input | 1 | Stack-overflow request |
| cnt_sign | input | 1 | Counter sign bit; its rising edge raises the underflow request |
| op | input | 4 | Interrupt operation code (0 = no operation) |
| data_in | input | 16 | Data port value for the current operation |
| take | output | 1 | One-cycle strobe marking that an interrupt was taken |
| vec_addr | output | 16 | Vector of the interrupt most recently taken |
| in_prog | output | 1 | Interrupt-in-progress flag |
| rd_data | output | 16 | Vector entry or status word from the latest read opcode |

## Verification
A corrupt mask or enable bit shows up within one cycle of the next read of the status word. Before that read, it shows up as a take that fires or fails to fire one edge after the request becomes pending. A latch that fails to clear, or clears when it should not, becomes visible as soon as in_prog drops: the block then takes a second interrupt, or fails to take it, at the very next edge. A pointer that is off by one shows up on the next read of a vector entry, or on the next take, as a vec_addr or rd_data value that comes from the wrong entry.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int N_EXT_D  = 8;
    localparam int DATA_W_D = 16;
    localparam int PTR_W_D  = 4;
    localparam int PTR_LSB  = 4;
    localparam int EN_BIT   = 2;
    localparam int MODE_BIT = 0;

    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_CLR_CUR   = 4'd1,
        OP_CLR_ALL   = 4'd2,
        OP_RD_VEC    = 4'd3,
        OP_WR_VEC    = 4'd4,
        OP_MASK_CLR  = 4'd5,
        OP_MASK_SET  = 4'd6,
        OP_DISABLE   = 4'd7,
        OP_ENABLE    = 4'd8,
        OP_SEL_LATCH = 4'd9,
        OP_SEL_TRANS = 4'd10,
        OP_LOAD_PTR  = 4'd11,
        OP_CLR_UNDER = 4'd12,
        OP_RD_STAT   = 4'd13
    } vic_op_e;

    // Build the status word: mask in the top bits, enable and mode below.
    function automatic logic [DATA_W_D-1:0] pack_status(
        input logic [N_EXT_D+1:0] mask,
        input logic               en,
        input logic               mode
    );
        logic [DATA_W_D-1:0] w;
        w = '0;
        w[DATA_W_D-1 -: N_EXT_D+2] = mask;
        w[EN_BIT]   = en;
        w[MODE_BIT] = mode;
        return w;
    endfunction

endpackage

// File: rtl/vic_req_latch.sv
module vic_req_latch
    import vic_pkg::*;
#(
    parameter int N_EXT = 8,
    parameter int ID_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  vic_op_e           op,
    input  logic              mode_q,
    input  logic [ID_W-1:0]   cur_id,
    input  logic [N_EXT-1:0]  ext_req,
    input  logic              ovf_req,
    input  logic              cnt_sign,
    output logic [N_EXT+1:0]  pend
);
    localparam int FIRST_EXT = 2;

    logic [N_EXT-1:0] ext_q;
    logic [N_EXT-1:0] clr_cur;
    logic [N_EXT-1:0] clr_vec;
    logic             und_q;
    logic             ovf_q;
    logic             sign_d;

    // Per-line clear decode for the interrupt being serviced
    for (genvar g = 0; g < N_EXT; g++) begin : g_clr
        assign clr_cur[g] = (op == OP_CLR_CUR) && (cur_id == ID_W'(g + FIRST_EXT));
    end

    assign clr_vec = (op == OP_CLR_ALL) ? '1 : clr_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q  <= '0;
            und_q  <= 1'b0;
            ovf_q  <= 1'b0;
            sign_d <= 1'b0;
        end else begin
            sign_d <= cnt_sign;
            und_q  <= (cnt_sign & ~sign_d) | (und_q & (op != OP_CLR_UNDER));
            ovf_q  <= ovf_req | (ovf_q & (op != OP_LOAD_PTR));
            if (mode_q || (op == OP_SEL_TRANS)) begin
                ext_q <= '0;
            end else begin
                ext_q <= (ext_q & ~clr_vec) | ext_req;
            end
        end
    end

    assign pend = {ext_q, ovf_q, und_q};

    // R10
    r10_under_kept_chk: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_CLR_CUR || op == OP_CLR_ALL) && und_q) |=> und_q);

    // R10
    r10_ovf_kept_chk: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_CLR_CUR || op == OP_CLR_ALL) && ovf_q) |=> ovf_q);

    // R11
    r11_trans_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SEL_TRANS) |=> (ext_q == '0));

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int NREQ = 10,
    parameter int ID_W = 4
) (
    input  logic [NREQ-1:0] req,
    output logic            any,
    output logic [ID_W-1:0] win
);
    logic [NREQ-1:0] above;
    logic [NREQ-1:0] grant;

    // Higher index beats lower: a line wins when nothing above it is active
    for (genvar g = 0; g < NREQ; g++) begin : g_pri
        if (g == NREQ - 1) begin : g_top
            assign above[g] = 1'b0;
        end else begin : g_low
            assign above[g] = above[g+1] | req[g+1];
        end
        assign grant[g] = req[g] & ~above[g];
    end

    assign any = |req;

    always_comb begin
        win = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (grant[i]) win = win | ID_W'(i);
        end
    end

endmodule

// File: rtl/vic_vecfile.sv
module vic_vecfile
    import vic_pkg::*;
#(
    parameter int NREQ   = 10,
    parameter int DATA_W = 16,
    parameter int PTR_W  = 4,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  vic_op_e           op,
    input  logic [DATA_W-1:0] data_in,
    input  logic [ID_W-1:0]   win_id,
    output logic [DATA_W-1:0] win_vec,
    output logic [DATA_W-1:0] rd_vec
);
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] mem_q [NREQ];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < NREQ; i++) mem_q[i] <= '0;
        end else begin
            if (op == OP_WR_VEC) begin
                for (int i = 0; i < NREQ; i++) begin
                    if (ptr_q == PTR_W'(i)) mem_q[i] <= data_in;
                end
            end
            if (op == OP_RD_VEC || op == OP_WR_VEC) begin
                ptr_q <= ptr_q + 1'b1;
            end else if (op == OP_LOAD_PTR) begin
                ptr_q <= data_in[PTR_LSB +: PTR_W];
            end
        end
    end

    always_comb begin
        rd_vec  = '0;
        win_vec = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (ptr_q == PTR_W'(i))  rd_vec  = mem_q[i];
            if (win_id == ID_W'(i))  win_vec = mem_q[i];
        end
    end

    // R12
    r12_ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RD_VEC || op == OP_WR_VEC) |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int N_EXT  = vic_pkg::N_EXT_D,
    parameter int DATA_W = vic_pkg::DATA_W_D,
    parameter int PTR_W  = vic_pkg::PTR_W_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EXT-1:0]  ext_req,
    input  logic              ovf_req,
    input  logic              cnt_sign,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] data_in,
    output logic              take,
    output logic [DATA_W-1:0] vec_addr,
    output logic              in_prog,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NREQ = N_EXT + 2;
    localparam int ID_W = $clog2(NREQ);

    vic_op_e           op_e;
    logic [NREQ-1:0]   pend;
    logic [NREQ-1:0]   eff_req;
    logic [NREQ-1:0]   cand;
    logic [NREQ-1:0]   mask_q;
    logic              en_q;
    logic              mode_q;
    logic              inp_q;
    logic [ID_W-1:0]   cur_q;
    logic              take_q;
    logic [DATA_W-1:0] vaddr_q;
    logic [DATA_W-1:0] rd_q;
    logic              any_req;
    logic [ID_W-1:0]   win_id;
    logic [DATA_W-1:0] win_vec;
    logic [DATA_W-1:0] rd_vec;
    logic [NREQ-1:0]   mask_bits;
    logic              take_now;

    assign op_e      = vic_op_e'(op);
    assign mask_bits = data_in[DATA_W-1 -: NREQ];

    vic_req_latch #(.N_EXT(N_EXT), .ID_W(ID_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .op       (op_e),
        .mode_q   (mode_q),
        .cur_id   (cur_q),
        .ext_req  (ext_req),
        .ovf_req  (ovf_req),
        .cnt_sign (cnt_sign),
        .pend     (pend)
    );

    // Transparent mode uses the live lines; latched mode the stored ones
    assign eff_req = mode_q ? {ext_req, pend[1:0]} : pend;
    assign cand    = eff_req & ~mask_q;

    vic_arbiter #(.NREQ(NREQ), .ID_W(ID_W)) u_arb (
        .req (cand),
        .any (any_req),
        .win (win_id)
    );

    vic_vecfile #(.NREQ(NREQ), .DATA_W(DATA_W), .PTR_W(PTR_W), .ID_W(ID_W)) u_vec (
        .clk     (clk),
        .rst     (rst),
        .op      (op_e),
        .data_in (data_in),
        .win_id  (win_id),
        .win_vec (win_vec),
        .rd_vec  (rd_vec)
    );

    assign take_now = en_q & ~inp_q & any_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            en_q    <= 1'b0;
            mode_q  <= 1'b0;
            inp_q   <= 1'b0;
            cur_q   <= '0;
            take_q  <= 1'b0;
            vaddr_q <= '0;
            rd_q    <= '0;
        end else begin
            take_q <= take_now;
            if (take_now) begin
                inp_q   <= 1'b1;
                cur_q   <= win_id;
                vaddr_q <= win_vec;
            end else if (op_e == OP_CLR_CUR || op_e == OP_CLR_ALL) begin
                inp_q <= 1'b0;
            end

            unique case (op_e)
                OP_MASK_SET:  mask_q <= mask_q | mask_bits;
                OP_MASK_CLR:  mask_q <= mask_q & ~mask_bits;
                OP_ENABLE:    en_q   <= 1'b1;
                OP_DISABLE:   en_q   <= 1'b0;
                OP_SEL_TRANS: mode_q <= 1'b1;
                OP_SEL_LATCH: mode_q <= 1'b0;
                OP_RD_VEC:    rd_q   <= rd_vec;
                OP_RD_STAT:   rd_q   <= pack_status(mask_q, en_q, mode_q);
                default:      ;
            endcase
        end
    end

    assign take     = take_q;
    assign vec_addr = vaddr_q;
    assign in_prog  = inp_q;
    assign rd_data  = rd_q;

    // R5
    r5_take_flag_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> in_prog);

    // R7
    r7_single_take_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    // R4
    r4_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !take);

    // R3
    r3_mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (op_e == OP_MASK_SET) |=> ((mask_q & $past(mask_bits)) == $past(mask_bits)));

    // R3
    r3_mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (op_e == OP_MASK_CLR) |=> ((mask_q & $past(mask_bits)) == '0));

endmodule

// File: tb/vic_ctrl_test.sv
`timescale 1ns/1ps
module vic_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  ext_req;
    logic        ovf_req;
    logic        cnt_sign;
    logic [3:0]  op;
    logic [15:0] data_in;
    logic        take;
    logic [15:0] vec_addr;
    logic        in_prog;
    logic [15:0] rd_data;

    always #2 clk = ~clk;

    vic_ctrl uut (
        .clk      (clk),
        .rst      (rst),
        .ext_req  (ext_req),
        .ovf_req  (ovf_req),
        .cnt_sign (cnt_sign),
        .op       (op),
        .data_in  (data_in),
        .take     (take),
        .vec_addr (vec_addr),
        .in_prog  (in_prog),
        .rd_data  (rd_data)
    );

    int checks = 0;
    int fails  = 0;

    // Stimulus held between steps
    logic [7:0] g_ext  = '0;
    logic       g_ovf  = 1'b0;
    logic       g_sign = 1'b0;

    // Expected-state model
    logic [7:0]  m_ext;
    logic        m_und, m_ovf, m_sign;
    logic [9:0]  m_mask;
    logic        m_en, m_mode, m_inp;
    int          m_cur;
    logic        m_take;
    logic [15:0] m_vaddr, m_rd;
    logic [15:0] m_vec [16];
    logic [3:0]  m_ptr;

    function automatic int top_idx(input logic [9:0] v);
        int r = -1;
        for (int i = 0; i < 10; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [15:0] stat_word(input logic [9:0] mk, input logic en, input logic md);
        logic [15:0] w = '0;
        w[15:6] = mk;
        w[2]    = en;
        w[0]    = md;
        return w;
    endfunction

    task automatic model_reset();
        m_ext = '0; m_und = 0; m_ovf = 0; m_sign = 0;
        m_mask = '0; m_en = 0; m_mode = 0; m_inp = 0; m_cur = 0;
        m_take = 0; m_vaddr = '0; m_rd = '0; m_ptr = '0;
        for (int i = 0; i < 16; i++) m_vec[i] = '0;
    endtask

    task automatic model_edge(input logic [3:0] o, input logic [15:0] d);
        logic [9:0] eff, cand;
        logic [7:0] nx;
        int         w;
        logic       tk;
        eff  = m_mode ? {g_ext, m_ovf, m_und} : {m_ext, m_ovf, m_und};
        cand = eff & ~m_mask;
        w    = top_idx(cand);
        tk   = m_en && !m_inp && (w >= 0);
        if (m_mode || o == 4'd10) nx = '0;
        else begin
            nx = m_ext;
            if (o == 4'd2) nx = '0;
            else if (o == 4'd1 && m_cur >= 2) nx[m_cur-2] = 1'b0;
            nx = nx | g_ext;
        end
        if (o == 4'd3) m_rd = (m_ptr < 10) ? m_vec[m_ptr] : 16'h0;
        if (o == 4'd13) m_rd = stat_word(m_mask, m_en, m_mode);
        m_take = tk;
        if (tk) begin
            m_vaddr = m_vec[w];
            m_cur   = w;
            m_inp   = 1'b1;
        end else if (o == 4'd1 || o == 4'd2) m_inp = 1'b0;
        m_ext = nx;
        m_und = (g_sign && !m_sign) ? 1'b1 : ((o == 4'd12) ? 1'b0 : m_und);
        m_ovf = g_ovf ? 1'b1 : ((o == 4'd11) ? 1'b0 : m_ovf);
        m_sign = g_sign;
        if (o == 4'd6) m_mask = m_mask | d[15:6];
        if (o == 4'd5) m_mask = m_mask & ~d[15:6];
        if (o == 4'd8) m_en = 1'b1;
        if (o == 4'd7) m_en = 1'b0;
        if (o == 4'd10) m_mode = 1'b1;
        if (o == 4'd9) m_mode = 1'b0;
        if (o == 4'd4 && m_ptr < 10) m_vec[m_ptr] = d;
        if (o == 4'd3 || o == 4'd4) m_ptr = m_ptr + 1'b1;
        else if (o == 4'd11) m_ptr = d[7:4];
    endtask

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, model the rising edge, compare at the next falling edge
    task automatic step(input logic [3:0] o, input logic [15:0] d, input string tag);
        op = o; data_in = d; ext_req = g_ext; ovf_req = g_ovf; cnt_sign = g_sign;
        @(posedge clk);
        model_edge(o, d);
        @(negedge clk);
        chk(tag, "take",     {15'd0, take},    {15'd0, m_take});
        chk(tag, "vec_addr", vec_addr,         m_vaddr);
        chk(tag, "in_prog",  {15'd0, in_prog}, {15'd0, m_inp});
        chk(tag, "rd_data",  rd_data,          m_rd);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(4'd0, 16'h0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; op = '0; data_in = '0; ext_req = '0; ovf_req = 0; cnt_sign = 0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        // R1: literal reset values
        chk("R1", "take",     {15'd0, take},    16'h0);
        chk("R1", "in_prog",  {15'd0, in_prog}, 16'h0);
        chk("R1", "rd_data",  rd_data,          16'h0);
        step(4'd13, 16'hFFFF, "R1");
        chk("R1", "status", rd_data, 16'h0000);

        // R12: vector file write, pointer wrap region, readback
        step(4'd11, 16'h0000, "R12");
        for (int k = 0; k < 10; k++) step(4'd4, 16'hA000 + 16'(k * 16'h0111), "R12");
        step(4'd4, 16'hDEAD, "R12");
        step(4'd11, 16'h00A0, "R12");
        step(4'd3, 16'h0, "R12");
        chk("R12", "empty entry", rd_data, 16'h0000);
        step(4'd11, 16'h0030, "R12");
        step(4'd3, 16'h0, "R12");
        chk("R12", "entry3", rd_data, 16'hA333);
        step(4'd3, 16'h0, "R12");
        step(4'd11, 16'h00F0, "R12");
        step(4'd3, 16'h0, "R12");
        step(4'd3, 16'h0, "R12");
        chk("R12", "wrap to 0", rd_data, 16'hA000);

        // R2 / R3: bitwise mask, low data bits ignored
        step(4'd6, 16'hFFFF, "R3");
        step(4'd13, 16'h0, "R2");
        chk("R2", "all masked", rd_data, 16'hFFC0);
        step(4'd5, 16'h553F, "R3");
        step(4'd13, 16'h0, "R3");
        chk("R3", "partial clear", rd_data, 16'hAAC0);
        step(4'd5, 16'hFFFF, "R3");
        step(4'd13, 16'h0, "R3");
        chk("R3", "cleared", rd_data, 16'h0000);

        // R4: disabled still latches; enable then takes request 5
        g_ext = 8'h08; step(4'd0, 16'h0, "R4");
        g_ext = 8'h00; idle(3, "R4");
        step(4'd8, 16'h0, "R4");
        step(4'd0, 16'h0, "R5");
        chk("R5", "vector5", vec_addr, 16'hA555);
        step(4'd13, 16'h0, "R2");
        chk("R2", "enabled", rd_data, 16'h0004);

        // R7 / R6 / R8: hold while busy, then highest first
        g_ext = 8'h81; step(4'd0, 16'h0, "R7");
        g_ext = 8'h00; idle(2, "R7");
        step(4'd1, 16'h0, "R8");
        step(4'd0, 16'h0, "R6");
        chk("R6", "vector9", vec_addr, 16'hA999);
        step(4'd1, 16'h0, "R8");
        step(4'd0, 16'h0, "R8");
        chk("R8", "vector2", vec_addr, 16'hA222);

        // R9: clear-all drops external latches
        g_ext = 8'h10; step(4'd0, 16'h0, "R9");
        g_ext = 8'h00; step(4'd2, 16'h0, "R9");
        idle(2, "R9");
        chk("R9", "no take", {15'd0, take}, 16'h0);

        // R10: internal requests survive clears
        step(4'd6, 16'hFF00, "R10");
        g_sign = 1'b1; step(4'd0, 16'h0, "R10");
        idle(2, "R10");
        chk("R10", "underflow vector", vec_addr, 16'hA000);
        step(4'd2, 16'h0, "R10");
        idle(1, "R10");
        chk("R10", "underflow retaken", {15'd0, take}, 16'h0001);
        step(4'd12, 16'h0, "R10");
        step(4'd1, 16'h0, "R10");
        idle(2, "R10");
        g_ovf = 1'b1; step(4'd0, 16'h0, "R10");
        g_ovf = 1'b0; idle(2, "R10");
        step(4'd11, 16'h0000, "R10");
        step(4'd1, 16'h0, "R10");
        idle(2, "R10");
        step(4'd5, 16'hFFFF, "R10");

        // R11: transparent mode
        g_ext = 8'h02; step(4'd1, 16'h0, "R11");
        g_ext = 8'h00; step(4'd10, 16'h0, "R11");
        idle(2, "R11");
        step(4'd1, 16'h0, "R11");
        g_ext = 8'h04; step(4'd0, 16'h0, "R11");
        chk("R11", "same-edge take", {15'd0, take}, 16'h0001);
        g_ext = 8'h00; step(4'd1, 16'h0, "R11");
        step(4'd9, 16'h0, "R11");
        idle(2, "R11");

        // R5: constrained random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] o;
            o = ($urandom % 100 < 35) ? 4'd0 : 4'($urandom % 16);
            g_ext = ($urandom % 6 == 0) ? 8'($urandom & $urandom) : 8'h00;
            g_ovf = ($urandom % 40 == 0);
            if ($urandom % 12 == 0) g_sign = ~g_sign;
            step(o, 16'($urandom), "R5");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule